// File: doc/BRIEF.md
# Single-Cycle Integer Core (Register, Immediate, Upper-Immediate and Load Subset)

This block is a minimal processor that completes one 32-bit instruction in every clock cycle. Each cycle it presents the program counter to an instruction port and receives the instruction word combinationally. It slices the word into fields and builds every immediate form, then routes operands through one shared arithmetic/logic unit. The result is written to a 32-entry register file whose entry zero always reads as zero. The instruction forms covered are register-immediate arithmetic (shift-immediates included), register-register arithmetic, load-upper-immediate and the five load widths. Stores, branches, jumps, PC-relative upper immediates and traps are not part of this block.

A decode unit extracts the fields without regard to instruction class. A control unit turns the opcode and function fields into selects for the second ALU operand, the immediate form, the write-back source and the ALU operation. The data memory is external and does the byte/halfword extraction and extension itself. The core supplies the address and a width/extension code and takes the already-extended word back in the same cycle. Every register write is reported one clock later on a retire port, and a sticky flag marks a malformed shift encoding.

Top module: `rv_core_single`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter becomes 0 (`imem_addr` reads 0), `retire_valid` becomes 0 and `illegal_flag` becomes 0.
- R2: Outside reset the program counter advances by 4 on every clock edge, and `imem_addr` always shows the address of the instruction being executed.
- R3: Opcode 0010011 writes rd with rs1 combined with the I immediate (bits 31:20 sign-extended), with funct3 000 add, 010 signed less-than, 011 unsigned less-than, 100 xor, 110 or, 111 and.
- R4: In opcode 0010011, funct3 001 shifts left and funct3 101 shifts right, by the 5-bit amount in bits 24:20 taken unsigned. With funct3 101, bits 31:25 equal to 0000000 select a logical shift and 0100000 an arithmetic shift.
- R5: Opcode 0110011 uses the rs2 register value as second operand, with the same funct3 meaning as R3/R4. Bits 31:25 equal to 0100000 turn funct3 000 into subtract and funct3 101 into an arithmetic right shift.
- R6: Opcode 0110111 writes rd with instruction bits 31:12 followed by twelve zero bits, without passing through the ALU.
- R7: Opcode 0000011 drives `dmem_addr` with rs1 plus the sign-extended I immediate and `dmem_op` with funct3 (000 signed byte, 001 signed half, 010 word, 100 unsigned byte, 101 unsigned half). It writes rd with `dmem_rdata` in the same cycle.
- R8: One clock after a register-writing instruction executes, `retire_valid` is 1 and `retire_rd`/`retire_data` hold its destination and written value.
- R9: An instruction with rd = 0 writes nothing and produces no retire, and register 0 always reads as zero.
- R10: An opcode outside the four above writes no register, produces no retire and leaves `illegal_flag` unchanged.
- R11: Opcode 0010011 with funct3 101 and bits 31:25 other than 0000000 or 0100000 writes no register, produces no retire, and sets `illegal_flag`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Byte address of the current instruction (registered PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Load byte address |
| dmem_op | output | 3 | Load width and extension code |
| dmem_rdata | input | 32 | Extended load data, combinational |
| retire_valid | output | 1 | A register write happened on the last edge |
| retire_rd | output | 5 | Destination of the last write |
| retire_data | output | 32 | Value of the last write |
| illegal_flag | output | 1 | Sticky malformed-shift indicator |

## Verification
The bench builds the core with its defaults: 32 registers, a 32-bit program counter and a reset address of 0. This lets a straight-line program run from address 0 with each table row matching one fetch slot. It also means every register index in the instruction format reaches real storage, so the zero-register rule and writes to the top entries are both exercised. Negative immediates, sign-bit shifts and a wrapping load address (a negative base plus an offset) come within reach this way. The malformed shift, an unsupported opcode and a second reset are run after the table, in the same program flow.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [6:0] OPC_ARITH_IMM = 7'b0010011;
  localparam logic [6:0] OPC_ARITH_REG = 7'b0110011;
  localparam logic [6:0] OPC_UPPER     = 7'b0110111;
  localparam logic [6:0] OPC_LOAD      = 7'b0000011;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
  } alu_op_e;

  typedef enum logic {
    OPB_IMM,
    OPB_REG
  } opb_sel_e;

  typedef enum logic [1:0] {
    IMM_I,
    IMM_SH,
    IMM_U
  } imm_sel_e;

  typedef enum logic [1:0] {
    WB_ALU,
    WB_IMM,
    WB_MEM
  } wb_sel_e;

  typedef struct packed {
    alu_op_e    alu_op;
    opb_sel_e   opb_sel;
    imm_sel_e   imm_sel;
    wb_sel_e    wb_sel;
    logic       reg_we;
    logic       bad_shift;
    logic [2:0] mem_op;
  } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode (
  input  logic [31:0] instr,
  output logic [6:0]  opcode,
  output logic [4:0]  rd,
  output logic [4:0]  rs1,
  output logic [4:0]  rs2,
  output logic [2:0]  funct3,
  output logic [6:0]  funct7,
  output logic [31:0] imm_i,
  output logic [31:0] imm_sh,
  output logic [31:0] imm_u
);

  // Fields are sliced for every word; control decides which are meaningful.
  always_comb begin
    opcode = instr[6:0];
    rd     = instr[11:7];
    funct3 = instr[14:12];
    rs1    = instr[19:15];
    rs2    = instr[24:20];
    funct7 = instr[31:25];
    imm_i  = {{20{instr[31]}}, instr[31:20]};
    imm_sh = {27'd0, instr[24:20]};
    imm_u  = {instr[31:12], 12'd0};
  end

endmodule

// File: rtl/core_control.sv
module core_control
  import core_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrl_t      ctrl
);

  // funct3 shares one meaning between register and immediate forms.
  function automatic alu_op_e f3_to_op(input logic [2:0] f3);
    case (f3)
      3'b000:  f3_to_op = ALU_ADD;
      3'b001:  f3_to_op = ALU_SLL;
      3'b010:  f3_to_op = ALU_SLT;
      3'b011:  f3_to_op = ALU_SLTU;
      3'b100:  f3_to_op = ALU_XOR;
      3'b101:  f3_to_op = ALU_SRL;
      3'b110:  f3_to_op = ALU_OR;
      default: f3_to_op = ALU_AND;
    endcase
  endfunction

  logic is_shift_f3;
  assign is_shift_f3 = (funct3 == 3'b001) || (funct3 == 3'b101);

  always_comb begin
    ctrl.alu_op    = ALU_ADD;
    ctrl.opb_sel   = OPB_IMM;
    ctrl.imm_sel   = IMM_I;
    ctrl.wb_sel    = WB_ALU;
    ctrl.reg_we    = 1'b0;
    ctrl.bad_shift = 1'b0;
    ctrl.mem_op    = funct3;
    case (opcode)
      OPC_ARITH_IMM: begin
        ctrl.reg_we  = 1'b1;
        ctrl.alu_op  = f3_to_op(funct3);
        ctrl.imm_sel = is_shift_f3 ? IMM_SH : IMM_I;
        if (funct3 == 3'b101) begin
          if (funct7 == F7_ALT) begin
            ctrl.alu_op = ALU_SRA;
          end else if (funct7 != F7_BASE) begin
            ctrl.bad_shift = 1'b1;
            ctrl.reg_we    = 1'b0;
          end
        end
      end
      OPC_ARITH_REG: begin
        ctrl.reg_we  = 1'b1;
        ctrl.opb_sel = OPB_REG;
        ctrl.alu_op  = f3_to_op(funct3);
        if (funct7[5]) begin
          if (funct3 == 3'b000) ctrl.alu_op = ALU_SUB;
          if (funct3 == 3'b101) ctrl.alu_op = ALU_SRA;
        end
      end
      OPC_UPPER: begin
        ctrl.reg_we  = 1'b1;
        ctrl.imm_sel = IMM_U;
        ctrl.wb_sel  = WB_IMM;
      end
      OPC_LOAD: begin
        ctrl.reg_we = 1'b1;
        ctrl.wb_sel = WB_MEM;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  localparam int SHW = $clog2(W);

  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << shamt;
      ALU_SLT:  y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(W-1){1'b0}}, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = W'($signed(a) >>> shamt);
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] mem [NREGS];

  // No reset on the array so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];

  // R9: entry zero is never targeted by a committed write.
  a_r9_no_x0_write: assert property (@(posedge clk) disable iff (rst)
    we |-> (wa != '0));

endmodule

// File: rtl/rv_core_single.sv
module rv_core_single
  import core_pkg::*;
#(
  parameter int              NREGS    = 32,
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] PC_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [31:0]     dmem_addr,
  output logic [2:0]      dmem_op,
  input  logic [31:0]     dmem_rdata,
  output logic            retire_valid,
  output logic [4:0]      retire_rd,
  output logic [31:0]     retire_data,
  output logic            illegal_flag
);

  localparam int AW = $clog2(NREGS);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic [PC_W-1:0] pc;
  logic [6:0]  opcode;
  logic [4:0]  rd, rs1, rs2;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic [31:0] imm_i, imm_sh, imm_u;
  ctrl_t       ctl;
  logic [31:0] rs1_val, rs2_val, imm_val, alu_b, alu_y, wb_data;
  logic        wr_en;

  core_decode u_dec (
    .instr (imem_rdata),
    .opcode(opcode),
    .rd    (rd),
    .rs1   (rs1),
    .rs2   (rs2),
    .funct3(funct3),
    .funct7(funct7),
    .imm_i (imm_i),
    .imm_sh(imm_sh),
    .imm_u (imm_u)
  );

  core_control u_ctl (
    .opcode(opcode),
    .funct3(funct3),
    .funct7(funct7),
    .ctrl  (ctl)
  );

  always_comb begin
    case (ctl.imm_sel)
      IMM_SH:  imm_val = imm_sh;
      IMM_U:   imm_val = imm_u;
      default: imm_val = imm_i;
    endcase
  end

  assign alu_b = (ctl.opb_sel == OPB_REG) ? rs2_val : imm_val;

  core_alu #(.W(32)) u_alu (
    .op(ctl.alu_op),
    .a (rs1_val),
    .b (alu_b),
    .y (alu_y)
  );

  always_comb begin
    case (ctl.wb_sel)
      WB_IMM:  wb_data = imm_val;
      WB_MEM:  wb_data = dmem_rdata;
      default: wb_data = alu_y;
    endcase
  end

  assign wr_en = ctl.reg_we && (rd != 5'd0);

  core_regfile #(.NREGS(NREGS), .W(32)) u_rf (
    .clk(clk),
    .rst(rst),
    .ra1(rs1[AW-1:0]),
    .ra2(rs2[AW-1:0]),
    .rd1(rs1_val),
    .rd2(rs2_val),
    .we (wr_en),
    .wa (rd[AW-1:0]),
    .wd (wb_data)
  );

  assign imem_addr = pc;
  assign dmem_addr = alu_y;
  assign dmem_op   = ctl.mem_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc           <= PC_RESET;
      retire_valid <= 1'b0;
      retire_rd    <= 5'd0;
      retire_data  <= 32'd0;
      illegal_flag <= 1'b0;
    end else begin
      pc           <= pc + PC_STEP;
      retire_valid <= wr_en;
      retire_rd    <= rd;
      retire_data  <= wb_data;
      if (ctl.bad_shift) illegal_flag <= 1'b1;
    end
  end

  // Checker state for the PC step property.
  logic            run_q;
  logic [PC_W-1:0] pc_prev;
  always_ff @(posedge clk) begin
    run_q   <= !rst;
    pc_prev <= pc;
  end

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (imem_addr == pc_prev + PC_STEP));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal_flag |=> illegal_flag);

  a_r11_no_write_on_bad_shift: assert property (@(posedge clk) disable iff (rst)
    ctl.bad_shift |-> !wr_en);

  a_r5_reg_operand: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_ARITH_REG) |-> (alu_b == rs2_val));

  a_r6_upper_low_zero: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_UPPER) |-> (wb_data[11:0] == 12'd0));

  a_r9_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (rs1 == 5'd0) |-> (rs1_val == 32'd0));

  a_r10_no_write_unknown: assert property (@(posedge clk) disable iff (rst)
    ((opcode != OPC_ARITH_IMM) && (opcode != OPC_ARITH_REG) &&
     (opcode != OPC_UPPER) && (opcode != OPC_LOAD)) |=> !retire_valid);

endmodule

// File: tb/rv_core_single_test.sv
`timescale 1ns/1ps
module rv_core_single_test;

  localparam int WATCHDOG = 5000;

  typedef struct packed {
    logic [31:0] ins;
    logic        wen;
    logic [4:0]  rd;
    logic [31:0] val;
    logic        ld;
    logic [31:0] addr;
    logic [2:0]  op;
    logic        ill;
  } vec_t;

  function automatic logic [31:0] ei(input logic [11:0] imm, input logic [4:0] rs1,
                                     input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [6:0] opc);
    ei = {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] er(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd);
    er = {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction

  function automatic logic [31:0] eu(input logic [19:0] imm, input logic [4:0] rd);
    eu = {imm, rd, 7'b0110111};
  endfunction

  localparam logic [6:0] OI = 7'b0010011;
  localparam logic [6:0] OL = 7'b0000011;
  localparam logic [6:0] OS = 7'b0100011;
  localparam logic [31:0] MEMWORD = 32'h7A5E_8E9C;
  localparam logic [31:0] NOP = 32'h0000_0013;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{ei(12'h005, 5'd0, 3'd0, 5'd1,  OI), 1'b1, 5'd1,  32'h0000_0005, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'hFFD, 5'd0, 3'd0, 5'd2,  OI), 1'b1, 5'd2,  32'hFFFF_FFFD, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h00, 5'd2, 5'd1, 3'd0, 5'd3),  1'b1, 5'd3,  32'h0000_0002, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h20, 5'd2, 5'd1, 3'd0, 5'd4),  1'b1, 5'd4,  32'h0000_0008, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h00F, 5'd1, 3'd4, 5'd5,  OI), 1'b1, 5'd5,  32'h0000_000A, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h00, 5'd2, 5'd1, 3'd4, 5'd6),  1'b1, 5'd6,  32'hFFFF_FFF8, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h004, 5'd1, 3'd1, 5'd7,  OI), 1'b1, 5'd7,  32'h0000_0050, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h01C, 5'd2, 3'd5, 5'd8,  OI), 1'b1, 5'd8,  32'h0000_000F, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h401, 5'd2, 3'd5, 5'd9,  OI), 1'b1, 5'd9,  32'hFFFF_FFFE, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h000, 5'd2, 3'd2, 5'd10, OI), 1'b1, 5'd10, 32'h0000_0001, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'hFFF, 5'd1, 3'd3, 5'd11, OI), 1'b1, 5'd11, 32'h0000_0001, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h00, 5'd2, 5'd1, 3'd2, 5'd12), 1'b1, 5'd12, 32'h0000_0000, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h00, 5'd2, 5'd1, 3'd3, 5'd13), 1'b1, 5'd13, 32'h0000_0001, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h0F0, 5'd1, 3'd6, 5'd14, OI), 1'b1, 5'd14, 32'h0000_00F5, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h7FF, 5'd2, 3'd7, 5'd15, OI), 1'b1, 5'd15, 32'h0000_07FD, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h00, 5'd1, 5'd2, 3'd5, 5'd16), 1'b1, 5'd16, 32'h07FF_FFFF, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h20, 5'd1, 5'd2, 3'd5, 5'd17), 1'b1, 5'd17, 32'hFFFF_FFFF, 1'b0, 32'd0, 3'd0, 1'b0},
    '{er(7'h00, 5'd1, 5'd2, 3'd1, 5'd18), 1'b1, 5'd18, 32'hFFFF_FFA0, 1'b0, 32'd0, 3'd0, 1'b0},
    '{eu(20'h12345, 5'd19),               1'b1, 5'd19, 32'h1234_5000, 1'b0, 32'd0, 3'd0, 1'b0},
    '{eu(20'hFFFFF, 5'd20),               1'b1, 5'd20, 32'hFFFF_F000, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h007, 5'd1, 3'd0, 5'd0,  OI), 1'b0, 5'd0,  32'h0000_0000, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h003, 5'd0, 3'd0, 5'd21, OI), 1'b1, 5'd21, 32'h0000_0003, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h008, 5'd1, 3'd2, 5'd22, OL), 1'b1, 5'd22, 32'h7A5E_8E9C, 1'b1, 32'h0000_000D, 3'd2, 1'b0},
    '{ei(12'hFFF, 5'd1, 3'd0, 5'd23, OL), 1'b1, 5'd23, 32'hFFFF_FF9C, 1'b1, 32'h0000_0004, 3'd0, 1'b0},
    '{ei(12'h010, 5'd2, 3'd4, 5'd24, OL), 1'b1, 5'd24, 32'h0000_009C, 1'b1, 32'h0000_000D, 3'd4, 1'b0},
    '{ei(12'h000, 5'd3, 3'd1, 5'd25, OL), 1'b1, 5'd25, 32'hFFFF_8E9C, 1'b1, 32'h0000_0002, 3'd1, 1'b0},
    '{ei(12'h000, 5'd4, 3'd5, 5'd26, OL), 1'b1, 5'd26, 32'h0000_8E9C, 1'b1, 32'h0000_0008, 3'd5, 1'b0},
    '{er(7'h00, 5'd19, 5'd22, 3'd0, 5'd27), 1'b1, 5'd27, 32'h8C92_DE9C, 1'b0, 32'd0, 3'd0, 1'b0},
    '{ei(12'h022, 5'd1, 3'd5, 5'd5,  OI), 1'b0, 5'd0,  32'h0000_0000, 1'b0, 32'd0, 3'd0, 1'b1},
    '{ei(12'h000, 5'd1, 3'd0, 5'd6,  OS), 1'b0, 5'd0,  32'h0000_0000, 1'b0, 32'd0, 3'd0, 1'b1},
    '{ei(12'h001, 5'd1, 3'd0, 5'd28, OI), 1'b1, 5'd28, 32'h0000_0006, 1'b0, 32'd0, 3'd0, 1'b1},
    '{er(7'h00, 5'd0, 5'd5, 3'd0, 5'd29), 1'b1, 5'd29, 32'h0000_000A, 1'b0, 32'd0, 3'd0, 1'b1},
    '{er(7'h00, 5'd0, 5'd6, 3'd0, 5'd30), 1'b1, 5'd30, 32'hFFFF_FFF8, 1'b0, 32'd0, 3'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, retire_data;
  logic [2:0]  dmem_op;
  logic        retire_valid, illegal_flag;
  logic [4:0]  retire_rd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rv_core_single uut (
    .clk         (clk),
    .rst         (rst),
    .imem_addr   (imem_addr),
    .imem_rdata  (imem_rdata),
    .dmem_addr   (dmem_addr),
    .dmem_op     (dmem_op),
    .dmem_rdata  (dmem_rdata),
    .retire_valid(retire_valid),
    .retire_rd   (retire_rd),
    .retire_data (retire_data),
    .illegal_flag(illegal_flag)
  );

  // Instruction memory: table rows at consecutive words, NOPs beyond.
  assign imem_rdata = (imem_addr[31:2] < NV) ? VEC[imem_addr[31:2]].ins : NOP;

  // Data memory: one fixed word, extracted and extended by the op code.
  always_comb begin
    case (dmem_op)
      3'd0:    dmem_rdata = {{24{MEMWORD[7]}}, MEMWORD[7:0]};
      3'd1:    dmem_rdata = {{16{MEMWORD[15]}}, MEMWORD[15:0]};
      3'd4:    dmem_rdata = {24'd0, MEMWORD[7:0]};
      3'd5:    dmem_rdata = {16'd0, MEMWORD[15:0]};
      default: dmem_rdata = MEMWORD;
    endcase
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(imem_addr == 32'd0, "R1 pc", imem_addr, 32'd0);
    chk(retire_valid == 1'b0, "R1 retire_valid", {31'd0, retire_valid}, 32'd0);
    chk(illegal_flag == 1'b0, "R1 illegal_flag", {31'd0, illegal_flag}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      // R2: fetch address of row i
      chk(imem_addr == 32'(4 * i), "R2 pc step", imem_addr, 32'(4 * i));
      if (VEC[i].ld) begin
        chk(dmem_addr == VEC[i].addr, "R7 load address", dmem_addr, VEC[i].addr);
        chk(dmem_op == VEC[i].op, "R7 load op", {29'd0, dmem_op}, {29'd0, VEC[i].op});
      end
      @(negedge clk);
      // R8/R9/R10/R11: retire presence; R3-R7 values
      chk(retire_valid == VEC[i].wen, "R8 retire_valid (R9 R10 R11)",
          {31'd0, retire_valid}, {31'd0, VEC[i].wen});
      if (VEC[i].wen) begin
        chk(retire_rd == VEC[i].rd, "R8 retire_rd", {27'd0, retire_rd}, {27'd0, VEC[i].rd});
        chk(retire_data == VEC[i].val, "R3 R4 R5 R6 R7 retire_data", retire_data, VEC[i].val);
      end
      chk(illegal_flag == VEC[i].ill, "R11 illegal_flag (R10 unchanged)",
          {31'd0, illegal_flag}, {31'd0, VEC[i].ill});
    end

    // R1: reset mid-run clears the sticky flag and the PC
    rst = 1'b1;
    @(negedge clk);
    chk(imem_addr == 32'd0, "R1 pc after rerun reset", imem_addr, 32'd0);
    chk(retire_valid == 1'b0, "R1 retire after rerun reset", {31'd0, retire_valid}, 32'd0);
    chk(illegal_flag == 1'b0, "R11 flag cleared by reset", {31'd0, illegal_flag}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(retire_valid && retire_rd == 5'd1 && retire_data == 32'd5,
        "R3 first row after reset", retire_data, 32'd5);
    chk(imem_addr == 32'd4, "R2 pc after reset", imem_addr, 32'd4);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule